// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a port of general-purpose input pins and turns selected pin activity into one shared interrupt line. Every pin passes through a two-stage synchronizer and is then compared against its own registered previous level, so each pin can be set to trigger on a low level, a high level, a rising edge, a falling edge, or any edge. Edge events are held in a sticky status bit until software clears them by writing 1. Level events are shown live for as long as the level holds. Detection works on the synchronized input level alone, so it keeps working when the pin's pad is also driving an alternate peripheral.

A small register file holds the per-pin enable bits and the trigger mode. The mode is stored as three bit-planes, one register per mode bit. The same file gives read access to the status bits, a write-1-to-clear action on status, and read access to the synchronized pin levels. Writing a new mode to a pin drops any edge event recorded under the old mode.

A second, always-running clock drives a separate wake detector. It has its own synchronizer and edge comparison, and it pulses a wake request when an enabled pin in an edge mode changes in the right direction. Because of this it keeps working while the system clock is stopped. Pins in a level mode never raise a wake request.

Top module: `pinirq_unit`

## Requirements
- R1: After reset the enable, all three mode planes and the status register read 0, and both `irq_o` and `wake_o` are 0. Mode code 0 (rising edge) is the reset mode.
- R2: Mode code 3 (level low) and mode code 4 (level high) make a pin's status bit (bit n at address 4) show the level condition two clock edges after the pin changes. The bit drops again when the condition ends.
- R3: Mode code 0 (rising), 1 (falling) and 2 (either edge) set the pin's status bit three clock edges after a matching transition. A non-matching transition leaves the bit at 0. Codes 5 to 7 detect nothing.
- R4: An edge status bit stays set until a write to address 4 has 1 in that bit. Writing 0 in that bit, or leaving the register untouched, keeps it set.
- R5: When an edge is detected in the same cycle as a write-1 clear of its bit, the bit stays set.
- R6: In a level mode, a write-1 clear has no effect on a status bit while its level condition holds.
- R7: `irq_o` is 1 exactly when some pin has both its status bit and its enable bit (address 0, bit n) set. A disabled pin still records status.
- R8: A write to mode plane k (address 1+k, bit n holds mode bit k of pin n) that changes pin n's mode clears that pin's edge status. A plane write that leaves the mode unchanged does not.
- R9: `wake_o` pulses for one `wake_clk` cycle after an enabled pin in an edge mode makes a matching transition, even while `clk` is stopped. Level modes and disabled pins produce no pulse.
- R10: Reading address 5 returns the synchronized pin levels. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for registers and the interrupt path |
| wake_clk | input | 1 | Always-running clock for the wake detector |
| rst | input | 1 | Synchronous active-high reset, held across both clocks |
| pin_i | input | NPINS | Asynchronous pin input levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | NPINS | Register write data |
| rdata | output | NPINS | Register read data, combinational from `addr` |
| irq_o | output | 1 | Shared port interrupt |
| wake_o | output | 1 | Wake request pulse in the `wake_clk` domain |

## Verification
A pin change driven between clock edges becomes visible in a level status bit after two rising edges (synchronizer only). It reaches an edge status bit and `irq_o` after three (synchronizer plus the previous-level register). The wake pulse follows the same three-edge count on `wake_clk`. The bench drives inputs on falling edges and waits exactly that many edges before it samples on a falling edge. Register writes take effect at the single rising edge inside the write task. The clear-race case is timed so that the clear commits on the same edge at which the detector sees the transition. Wake pulses are counted on falling edges of `wake_clk` while `clk` is held stopped.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    // width of a per-pin trigger mode code
    localparam int MODE_W = 3;
    // width of the register address
    localparam int ADDR_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_EN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LEVEL = 3'd5;

    // trigger codes; reset value 0 is an edge mode so an idle port is quiet
    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_HIGH = 3'd4
    } trig_e;

    typedef logic [MODE_W-1:0] mode_t;

    // per-pin detector result
    typedef struct packed {
        logic hit;     // edge seen this cycle in an edge mode
        logic flag;    // sticky edge status
        logic status;  // status as seen by software and irq logic
    } pin_evt_t;

    // address of mode bit-plane k
    function automatic logic [ADDR_W-1:0] plane_addr(input int k);
        return A_MODE0 + ADDR_W'(k);
    endfunction

    // edge match for the given mode, comparing new and previous level
    function automatic logic edge_hit(input mode_t m, input logic cur, input logic prv);
        logic r;
        case (m)
            TRIG_RISE: r = cur & ~prv;
            TRIG_FALL: r = ~cur & prv;
            TRIG_BOTH: r = cur ^ prv;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_level(input mode_t m);
        return (m == TRIG_LOW) || (m == TRIG_HIGH);
    endfunction

    // level condition for the given mode
    function automatic logic level_true(input mode_t m, input logic cur);
        logic r;
        case (m)
            TRIG_LOW:  r = ~cur;
            TRIG_HIGH: r = cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pinirq_cell.sv
module pinirq_cell
    import pinirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,    // synchronized pin level
    input  mode_t    mode,
    input  logic     clr,    // write-1 clear for this pin
    input  logic     mchg,   // mode of this pin is being changed
    output pin_evt_t evt
);

    logic prv_q;
    logic flag_q;
    logic hit;

    assign hit = edge_hit(mode, lvl, prv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q <= 1'b0;
        end else begin
            prv_q <= lvl;
        end
    end

    // priority: mode change flush, then new edge, then software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (mchg) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        evt.hit    = hit;
        evt.flag   = flag_q;
        evt.status = is_level(mode) ? level_true(mode, lvl) : flag_q;
    end

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
    import pinirq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NPINS-1:0]               wdata,
    input  logic [NPINS-1:0]               status_v,
    input  logic [NPINS-1:0]               level_v,
    output logic [NPINS-1:0]               en_v,
    output logic [NPINS-1:0][MODE_W-1:0]   mode_v,
    output logic [NPINS-1:0]               clr_v,
    output logic [NPINS-1:0]               mchg_v,
    output logic [NPINS-1:0]               rdata
);

    logic [NPINS-1:0]             en_q;
    logic [NPINS-1:0][MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (addr == A_EN) en_q <= wdata;
            for (int k = 0; k < MODE_W; k++) begin
                if (addr == plane_addr(k)) begin
                    for (int n = 0; n < NPINS; n++) mode_q[n][k] <= wdata[n];
                end
            end
        end
    end

    // pins whose mode differs after this plane write
    always_comb begin
        mchg_v = '0;
        for (int k = 0; k < MODE_W; k++) begin
            if (wr_en && (addr == plane_addr(k))) begin
                for (int n = 0; n < NPINS; n++) mchg_v[n] = wdata[n] ^ mode_q[n][k];
            end
        end
    end

    assign clr_v = (wr_en && (addr == A_STAT)) ? wdata : '0;

    always_comb begin
        rdata = '0;
        if (addr == A_EN)    rdata = en_q;
        if (addr == A_STAT)  rdata = status_v;
        if (addr == A_LEVEL) rdata = level_v;
        for (int k = 0; k < MODE_W; k++) begin
            if (addr == plane_addr(k)) begin
                for (int n = 0; n < NPINS; n++) rdata[n] = mode_q[n][k];
            end
        end
    end

    assign en_v   = en_q;
    assign mode_v = mode_q;

endmodule

// File: rtl/pinirq_wake.sv
module pinirq_wake
    import pinirq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic                         wake_clk,
    input  logic                         rst,
    input  logic [NPINS-1:0]             pin_i,
    input  logic [NPINS-1:0]             en_v,     // quasi-static configuration
    input  logic [NPINS-1:0][MODE_W-1:0] mode_v,   // quasi-static configuration
    output logic                         wake_o
);

    logic [NPINS-1:0] lvl_w;
    logic [NPINS-1:0] prv_w_q;
    logic [NPINS-1:0] hit_w;
    logic             wake_q;

    pinirq_sync #(.WIDTH(NPINS), .STAGES(STAGES)) u_wsync (
        .clk (wake_clk),
        .rst (rst),
        .d   (pin_i),
        .q   (lvl_w)
    );

    // only edge modes match here, so level modes never request wake
    always_comb begin
        for (int n = 0; n < NPINS; n++) hit_w[n] = edge_hit(mode_v[n], lvl_w[n], prv_w_q[n]);
    end

    always_ff @(posedge wake_clk) begin
        if (rst) begin
            prv_w_q <= '0;
            wake_q  <= 1'b0;
        end else begin
            prv_w_q <= lvl_w;
            wake_q  <= |(hit_w & en_v);
        end
    end

    assign wake_o = wake_q;

endmodule

// File: rtl/pinirq_unit.sv
module pinirq_unit
    import pinirq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             wake_clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    output logic             irq_o,
    output logic             wake_o
);

    logic [NPINS-1:0]             level_v;
    logic [NPINS-1:0]             en_v;
    logic [NPINS-1:0][MODE_W-1:0] mode_v;
    logic [NPINS-1:0]             clr_v;
    logic [NPINS-1:0]             mchg_v;
    logic [NPINS-1:0]             status_v;
    logic [NPINS-1:0]             flag_v;
    logic [NPINS-1:0]             hit_v;

    pinirq_sync #(.WIDTH(NPINS), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (level_v)
    );

    pinirq_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .status_v (status_v),
        .level_v  (level_v),
        .en_v     (en_v),
        .mode_v   (mode_v),
        .clr_v    (clr_v),
        .mchg_v   (mchg_v),
        .rdata    (rdata)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pin_evt_t evt;
        pinirq_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .lvl  (level_v[g]),
            .mode (mode_v[g]),
            .clr  (clr_v[g]),
            .mchg (mchg_v[g]),
            .evt  (evt)
        );
        assign status_v[g] = evt.status;
        assign flag_v[g]   = evt.flag;
        assign hit_v[g]    = evt.hit;
    end

    // one shared vector for the whole port
    assign irq_o = |(status_v & en_v);

    pinirq_wake #(.NPINS(NPINS), .STAGES(STAGES)) u_wake (
        .wake_clk (wake_clk),
        .rst      (rst),
        .pin_i    (pin_i),
        .en_v     (en_v),
        .mode_v   (mode_v),
        .wake_o   (wake_o)
    );

endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             wake_clk,
    input logic             rst,
    input logic [NPINS-1:0] en_v,
    input logic [NPINS-1:0] status_v,
    input logic [NPINS-1:0] flag_v,
    input logic [NPINS-1:0] hit_v,
    input logic [NPINS-1:0] clr_v,
    input logic [NPINS-1:0] mchg_v,
    input logic             irq_o,
    input logic             wake_o
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (status_v == '0) && !irq_o);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(flag_v) & ~$past(clr_v) & ~$past(mchg_v) & ~flag_v) == '0));

    // R5
    clr_race_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(hit_v) & ~$past(mchg_v) & ~flag_v) == '0));

    // R8
    mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ((flag_v & $past(mchg_v)) == '0));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (en_v == '0) |-> !irq_o);

    // R9
    wake_needs_en_chk: assert property (@(posedge wake_clk) disable iff (rst)
        wake_o |-> (en_v != '0));

endmodule

bind pinirq_unit pinirq_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .wake_clk (wake_clk),
    .rst      (rst),
    .en_v     (en_v),
    .status_v (status_v),
    .flag_v   (flag_v),
    .hit_v    (hit_v),
    .clr_v    (clr_v),
    .mchg_v   (mchg_v),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
);

// File: tb/sim_pinirq_unit.sv
`timescale 1ns/1ps
module sim_pinirq_unit;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          clk_run = 1'b1;
    logic          wake_clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_i = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic          irq_o;
    logic          wake_o;

    int n_run = 0;
    int n_fail = 0;
    int wake_cnt = 0;
    bit done = 0;

    always #5 if (clk_run) clk = ~clk;
    always #20 wake_clk = ~wake_clk;

    always @(negedge wake_clk) if (!rst && wake_o) wake_cnt++;

    pinirq_unit #(.NPINS(NP), .STAGES(2)) u0 (
        .clk(clk), .wake_clk(wake_clk), .rst(rst), .pin_i(pin_i),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic stat_bit(input int p, output logic b);
        logic [NP-1:0] v;
        rd(3'd4, v);
        b = v[p];
    endtask

    task automatic set_mode(input int p, input logic [2:0] m);
        logic [NP-1:0] v;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rd(3'(k + 1), v);
            v[p] = m[k];
            wr(3'(k + 1), v);
        end
    endtask

    task automatic drive(input int p, input logic v);
        @(negedge clk);
        pin_i[p] = v;
    endtask

    // R1
    task automatic t_reset();
        logic [NP-1:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset reg %0d", a), v, '0);
        end
        chk("R1 reset irq_o", {31'b0, irq_o}, '0);
        chk("R1 reset wake_o", {31'b0, wake_o}, '0);
    endtask

    // R2 R6 R10
    task automatic t_level();
        logic b; logic [NP-1:0] v;
        set_mode(3, 3'd4);
        wr(3'd0, NP'(1) << 3);
        drive(3, 1'b1); settle(2);
        stat_bit(3, b); chk("R2 high level shown", {31'b0, b}, 1);
        chk("R7 irq on level", {31'b0, irq_o}, 1);
        rd(3'd5, v); chk("R10 level reg", v, NP'(1) << 3);
        rd(3'd6, v); chk("R10 unused addr", v, '0);
        wr(3'd4, NP'(1) << 3);
        stat_bit(3, b); chk("R6 level not cleared", {31'b0, b}, 1);
        drive(3, 1'b0); settle(2);
        stat_bit(3, b); chk("R2 high level dropped", {31'b0, b}, 0);
        chk("R7 irq dropped", {31'b0, irq_o}, 0);
        set_mode(4, 3'd3);
        stat_bit(4, b); chk("R2 low level shown", {31'b0, b}, 1);
        drive(4, 1'b1); settle(2);
        stat_bit(4, b); chk("R2 low level dropped", {31'b0, b}, 0);
        drive(4, 1'b0);
        set_mode(3, 3'd0); set_mode(4, 3'd0);
        wr(3'd0, '0);
    endtask

    // R3
    task automatic t_edges();
        logic b;
        drive(8, 1'b1); settle(3);
        stat_bit(8, b); chk("R3 rising set", {31'b0, b}, 1);
        wr(3'd4, NP'(1) << 8);
        drive(8, 1'b0); settle(3);
        stat_bit(8, b); chk("R3 rising ignores fall", {31'b0, b}, 0);
        set_mode(9, 3'd1);
        drive(9, 1'b1); settle(3);
        stat_bit(9, b); chk("R3 falling ignores rise", {31'b0, b}, 0);
        drive(9, 1'b0); settle(3);
        stat_bit(9, b); chk("R3 falling set", {31'b0, b}, 1);
        set_mode(10, 3'd2);
        drive(10, 1'b1); settle(3);
        stat_bit(10, b); chk("R3 both on rise", {31'b0, b}, 1);
        wr(3'd4, NP'(1) << 10);
        drive(10, 1'b0); settle(3);
        stat_bit(10, b); chk("R3 both on fall", {31'b0, b}, 1);
        set_mode(11, 3'd6);
        drive(11, 1'b1); settle(3);
        stat_bit(11, b); chk("R3 code 6 inert", {31'b0, b}, 0);
        drive(11, 1'b0); settle(3);
        set_mode(9, 3'd0); set_mode(10, 3'd0); set_mode(11, 3'd0);
        wr(3'd4, '1);
    endtask

    // R4
    task automatic t_sticky();
        logic b;
        drive(8, 1'b1); settle(3);
        wr(3'd4, ~(NP'(1) << 8));
        settle(4);
        stat_bit(8, b); chk("R4 zero write keeps bit", {31'b0, b}, 1);
        wr(3'd4, NP'(1) << 8);
        stat_bit(8, b); chk("R4 one write clears", {31'b0, b}, 0);
        drive(8, 1'b0); settle(3);
    endtask

    // R5
    task automatic t_race();
        logic b;
        drive(14, 1'b1); settle(3);
        stat_bit(14, b); chk("R5 first edge", {31'b0, b}, 1);
        drive(14, 1'b0); settle(3);
        drive(14, 1'b1);
        @(negedge clk);
        wr(3'd4, NP'(1) << 14);
        stat_bit(14, b); chk("R5 edge beats clear", {31'b0, b}, 1);
        wr(3'd4, NP'(1) << 14);
        stat_bit(14, b); chk("R5 later clear works", {31'b0, b}, 0);
        drive(14, 1'b0); settle(3);
    endtask

    // R7
    task automatic t_irq();
        logic b;
        drive(12, 1'b1); settle(3);
        stat_bit(12, b); chk("R7 status while disabled", {31'b0, b}, 1);
        chk("R7 irq masked", {31'b0, irq_o}, 0);
        wr(3'd0, NP'(1) << 12);
        chk("R7 irq raised", {31'b0, irq_o}, 1);
        wr(3'd4, NP'(1) << 12);
        chk("R7 irq cleared", {31'b0, irq_o}, 0);
        wr(3'd0, '0);
        drive(12, 1'b0); settle(3);
    endtask

    // R8
    task automatic t_mode();
        logic b; logic [NP-1:0] v;
        drive(13, 1'b1); settle(3);
        @(negedge clk); rd(3'd1, v);
        wr(3'd1, v);
        stat_bit(13, b); chk("R8 same mode keeps", {31'b0, b}, 1);
        set_mode(13, 3'd1);
        stat_bit(13, b); chk("R8 mode change flushes", {31'b0, b}, 0);
        drive(13, 1'b0); settle(3);
        set_mode(13, 3'd0);
        wr(3'd4, '1);
    endtask

    // R9
    task automatic t_wake();
        int base;
        set_mode(21, 3'd4);
        wr(3'd0, (NP'(1) << 20) | (NP'(1) << 21));
        #300;
        @(negedge clk);
        clk_run = 1'b0;
        base = wake_cnt;
        pin_i[20] = 1'b1; #240;
        chk("R9 wake on rise, clk stopped", NP'(wake_cnt - base), 1);
        base = wake_cnt;
        pin_i[21] = 1'b1; #240;
        chk("R9 no wake in level mode", NP'(wake_cnt - base), 0);
        pin_i[22] = 1'b1; #240;
        chk("R9 no wake when disabled", NP'(wake_cnt - base), 0);
        pin_i[20] = 1'b0; #240;
        chk("R9 no wake on wrong edge", NP'(wake_cnt - base), 0);
        clk_run = 1'b1;
        pin_i[21] = 1'b0; pin_i[22] = 1'b0;
        settle(3);
        set_mode(21, 3'd0);
        wr(3'd0, '0);
        wr(3'd4, '1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20) @(negedge clk);
        t_reset();
        rst = 1'b0;
        #200;
        t_reset();
        t_level();
        t_edges();
        t_sticky();
        t_race();
        t_irq();
        t_mode();
        t_wake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule